// File: doc/BRIEF.md
# Vector Length State and Element-Loop Sequencer

This block keeps the packed 32-bit vector-state word for one execution context. It steps a hardware loop that turns one scalar operation into a series of per-element writes. Software writes and reads the word through a simple register port. Length and maximum length are held minus one, and both are clamped as they are written. A separate request port sets the sub-vector group size from a plain count of 1 to 4. That port flags any count outside that range and does not change the word.

A start pulse launches the loop from the offsets currently held in the word. Each busy cycle presents one step: source offset, destination offset, sub-element offset, and whether to write the result or write zeros. The sub-element offset is the inner loop. The element index is the outer loop. One predicate bit, which can be inverted, covers a whole group of sub-elements. A fail-on-first stop cancels the current step and all later ones. The live offsets are mirrored in the state word, so a saved word can resume a loop mid-way. A one-cycle done pulse marks the end of the loop.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset the state word reads 0 (length 1, maximum length 1, group size 1, all offsets 0), and busy, done, wr_en, wr_zero and sv_illegal are all low.
- R2: While idle, a register write stores the word with this layout: bits 5:0 maximum length minus one, 11:6 length minus one, 17:12 source offset, 23:18 destination offset, 25:24 group-size code, 27:26 sub-element offset. Bits 31:28 always read as zero.
- R3: On a write, the maximum-length field is capped at MAX_LEN-1. The length field is then capped at the stored maximum-length field.
- R4: A group-size request of 1, 2, 3 or 4 stores code 0, 1, 2 or 3 in bits 25:24. Any other value leaves the word unchanged and raises sv_illegal for exactly the following cycle.
- R5: Starting from the held offsets, the loop presents one step per busy cycle, beginning in the cycle after start. The sub-element offset counts up to the group-size code. It then returns to 0 while the source and destination offsets each advance by one. The loop ends after the step where the sub-element offset equals the code and the destination offset is at or above the length field.
- R6: The predicate bit for a step is pred_mask[dst_off] XOR pred_inv. The bit is 0 when dst_off is at or above MAX_LEN. When this bit is 1, wr_en is high for every sub-element of that element.
- R7: When the predicate bit is 0, wr_zero is high if zeroing is set. If zeroing is clear, neither wr_en nor wr_zero is high.
- R8: In a busy cycle where ffirst is high, wr_en and wr_zero are low. No further step follows, and done rises in the next cycle.
- R9: The offset fields of the state word track the loop's current step. They are cleared to 0 when the loop ends or aborts.
- R10: done is high for exactly one cycle, in the cycle after the last step. While busy, start, register writes and group-size requests have no effect.
- R11: With length 1, group size 1 and an all-ones mask, one start yields exactly one step, with wr_en high at offsets 0, 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe for the state word |
| csr_wdata | input | 32 | State word write data |
| csr_rdata | output | 32 | Current state word |
| sv_we | input | 1 | Group-size request strobe |
| sv_len | input | 3 | Requested group size as a plain count |
| sv_illegal | output | 1 | Pulse: group-size request out of range |
| start | input | 1 | Launch the element loop |
| pred_mask | input | MAX_LEN | Predicate mask, one bit per element |
| pred_inv | input | 1 | Invert predicate bits |
| zeroing | input | 1 | Write zeros to masked-off positions |
| ffirst | input | 1 | Fail-on-first stop for the current step |
| busy | output | 1 | Loop is running; a step is presented |
| src_off | output | 6 | Source element offset of this step |
| dst_off | output | 6 | Destination element offset of this step |
| sub_off | output | 2 | Sub-element offset of this step |
| wr_en | output | 1 | Write the result at this step |
| wr_zero | output | 1 | Write zeros at this step |
| done | output | 1 | One-cycle pulse after the loop ends |

## Verification
The assertions assume four things about the inputs:
- csr_we and sv_we are never high in the same cycle.
- ffirst is only raised while a step is presented.
- pred_mask and the flags are steady during a step.
- MAX_LEN is at most 64.

The stimulus keeps within these limits by construction. It drives each strobe alone from its own task. It raises ffirst only at a chosen busy step and drops it at the next cycle. It writes offsets that lie inside the programmed length and group size, except in directed cases that check the end condition. Random words, group-size requests and abort points are mixed with directed cases for clamping, illegal sizes, resume, the single-element loop and writes made while busy.

// File: rtl/vls_pkg.sv
package vls_pkg;
   localparam int WORD_W = 32;
   localparam int LEN_W  = 6;
   localparam int CODE_W = 2;

   typedef struct packed {
      logic [3:0]        rsvd;
      logic [CODE_W-1:0] sub;
      logic [CODE_W-1:0] svl;
      logic [LEN_W-1:0]  dst;
      logic [LEN_W-1:0]  src;
      logic [LEN_W-1:0]  len;
      logic [LEN_W-1:0]  maxl;
   } vstate_t;
endpackage

// File: rtl/vls_state_reg.sv
module vls_state_reg
   import vls_pkg::*;
#(
   parameter int MAX_LEN = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy,
   input  logic                csr_we,
   input  logic [WORD_W-1:0]   csr_wdata,
   input  logic                sv_we,
   input  logic [2:0]          sv_len,
   input  logic                step_en,
   input  logic [LEN_W-1:0]    nxt_src,
   input  logic [LEN_W-1:0]    nxt_dst,
   input  logic [CODE_W-1:0]   nxt_sub,
   output vstate_t             state,
   output logic                sv_illegal
);
   localparam logic [LEN_W-1:0] MAXL_CAP = LEN_W'(MAX_LEN - 1);

   vstate_t wr_raw, wr_fix;
   logic    sv_ok;

   always_comb begin
      wr_raw      = vstate_t'(csr_wdata);
      wr_fix      = wr_raw;
      wr_fix.rsvd = '0;
      wr_fix.maxl = (wr_raw.maxl > MAXL_CAP) ? MAXL_CAP : wr_raw.maxl;
      wr_fix.len  = (wr_raw.len > wr_fix.maxl) ? wr_fix.maxl : wr_raw.len;
      sv_ok       = (sv_len != 3'd0) && (sv_len <= 3'd4);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= '0;
         sv_illegal <= 1'b0;
      end else begin
         sv_illegal <= 1'b0;
         if (step_en) begin
            state.src <= nxt_src;
            state.dst <= nxt_dst;
            state.sub <= nxt_sub;
         end else if (!busy) begin
            if (csr_we) begin
               state <= wr_fix;
            end else if (sv_we) begin
               if (sv_ok) state.svl <= CODE_W'(sv_len - 3'd1);
               else       sv_illegal <= 1'b1;
            end
         end
      end
   end

   AST_LEN_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n) state.len <= state.maxl); // R3
   AST_MAXL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n) state.maxl <= MAXL_CAP); // R3
   AST_ILLEGAL_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n) sv_illegal |-> $stable(state.svl)); // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) state.rsvd == 4'd0); // R2
endmodule

// File: rtl/vls_loop_ctl.sv
module vls_loop_ctl
   import vls_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                ffirst,
   input  vstate_t             state,
   output logic                busy,
   output logic                done,
   output logic                step_en,
   output logic [LEN_W-1:0]    nxt_src,
   output logic [LEN_W-1:0]    nxt_dst,
   output logic [CODE_W-1:0]   nxt_sub
);
   logic last_sub, last_elem, finish;

   always_comb begin
      last_sub  = (state.sub >= state.svl);
      last_elem = (state.dst >= state.len);
      finish    = busy && (ffirst || (last_sub && last_elem));
      step_en   = busy;
      nxt_src   = state.src;
      nxt_dst   = state.dst;
      nxt_sub   = state.sub;
      if (finish) begin
         nxt_src = '0;
         nxt_dst = '0;
         nxt_sub = '0;
      end else if (last_sub) begin
         nxt_sub = '0;
         nxt_src = state.src + 1'b1;
         nxt_dst = state.dst + 1'b1;
      end else begin
         nxt_sub = state.sub + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (!busy && start) busy <= 1'b1;
         else if (finish)    busy <= 1'b0;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R10
   AST_FF_STOPS: assert property (@(posedge clk) disable iff (!rst_n) (busy && ffirst) |=> !busy); // R8
   AST_OFFS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) done |-> (state.dst == '0 && state.sub == '0)); // R9
endmodule

// File: rtl/vls_pred_gate.sv
module vls_pred_gate
   import vls_pkg::*;
#(
   parameter int MAX_LEN = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                busy,
   input  logic [LEN_W-1:0]    dst,
   input  logic [MAX_LEN-1:0]  pred_mask,
   input  logic                pred_inv,
   input  logic                zeroing,
   input  logic                ffirst,
   output logic                wr_en,
   output logic                wr_zero
);
   logic raw_bit, pbit, live;

   generate
      if (MAX_LEN == (1 << LEN_W)) begin : g_full
         assign raw_bit = pred_mask[dst];
      end else begin : g_pad
         logic [(1 << LEN_W)-1:0] ext;
         assign ext     = (1 << LEN_W)'(pred_mask);
         assign raw_bit = ext[dst];
      end
   endgenerate

   assign pbit    = raw_bit ^ pred_inv;
   assign live    = busy && !ffirst;
   assign wr_en   = live && pbit;
   assign wr_zero = live && !pbit && zeroing;

   AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && wr_zero)); // R7
   AST_FF_CANCELS: assert property (@(posedge clk) disable iff (!rst_n) ffirst |-> (!wr_en && !wr_zero)); // R8
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!wr_en && !wr_zero)); // R1
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq
   import vls_pkg::*;
#(
   parameter int MAX_LEN = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_we,
   input  logic [31:0]         csr_wdata,
   output logic [31:0]         csr_rdata,
   input  logic                sv_we,
   input  logic [2:0]          sv_len,
   output logic                sv_illegal,
   input  logic                start,
   input  logic [MAX_LEN-1:0]  pred_mask,
   input  logic                pred_inv,
   input  logic                zeroing,
   input  logic                ffirst,
   output logic                busy,
   output logic [5:0]          src_off,
   output logic [5:0]          dst_off,
   output logic [1:0]          sub_off,
   output logic                wr_en,
   output logic                wr_zero,
   output logic                done
);
   generate
      if (MAX_LEN < 1 || MAX_LEN > (1 << LEN_W)) begin : g_bad_len
         $error("vec_loop_seq: MAX_LEN out of range");
      end
   endgenerate

   vstate_t             state;
   logic                step_en;
   logic [LEN_W-1:0]    nxt_src, nxt_dst;
   logic [CODE_W-1:0]   nxt_sub;

   vls_state_reg #(.MAX_LEN(MAX_LEN)) u_state (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .csr_we(csr_we), .csr_wdata(csr_wdata),
      .sv_we(sv_we), .sv_len(sv_len),
      .step_en(step_en), .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_sub(nxt_sub),
      .state(state), .sv_illegal(sv_illegal)
   );

   vls_loop_ctl u_loop (
      .clk(clk), .rst_n(rst_n), .start(start), .ffirst(ffirst), .state(state),
      .busy(busy), .done(done), .step_en(step_en),
      .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_sub(nxt_sub)
   );

   vls_pred_gate #(.MAX_LEN(MAX_LEN)) u_pred (
      .clk(clk), .rst_n(rst_n), .busy(busy), .dst(state.dst),
      .pred_mask(pred_mask), .pred_inv(pred_inv), .zeroing(zeroing), .ffirst(ffirst),
      .wr_en(wr_en), .wr_zero(wr_zero)
   );

   assign csr_rdata = state;
   assign src_off   = state.src;
   assign dst_off   = state.dst;
   assign sub_off   = state.sub;
endmodule

// File: tb/vec_loop_seq_tb_top.sv
module vec_loop_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ML = 48;

   logic clk = 0, rst_n = 0;
   logic csr_we = 0, sv_we = 0, start = 0, pred_inv = 0, zeroing = 0, ffirst = 0;
   logic [31:0] csr_wdata = 0, csr_rdata;
   logic [2:0] sv_len = 0;
   logic [ML-1:0] pred_mask = 0;
   logic sv_illegal, busy, wr_en, wr_zero, done;
   logic [5:0] src_off, dst_off;
   logic [1:0] sub_off;

   int n_chk = 0, n_bad = 0;
   int m_maxl = 0, m_len = 0, m_src = 0, m_dst = 0, m_svl = 0, m_sub = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_loop_seq #(.MAX_LEN(ML)) dut_i (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .sv_we(sv_we), .sv_len(sv_len), .sv_illegal(sv_illegal), .start(start),
      .pred_mask(pred_mask), .pred_inv(pred_inv), .zeroing(zeroing), .ffirst(ffirst),
      .busy(busy), .src_off(src_off), .dst_off(dst_off), .sub_off(sub_off),
      .wr_en(wr_en), .wr_zero(wr_zero), .done(done)
   );

   function automatic logic [31:0] pack_state();
      return {4'b0, 2'(m_sub), 2'(m_svl), 6'(m_dst), 6'(m_src), 6'(m_len), 6'(m_maxl)};
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic do_write(logic [31:0] w);
      @(negedge clk); csr_we = 1; csr_wdata = w;
      @(negedge clk); csr_we = 0;
      m_maxl = (w[5:0] > ML-1) ? ML-1 : int'(w[5:0]);
      m_len  = (w[11:6] > m_maxl) ? m_maxl : int'(w[11:6]);
      m_src = w[17:12]; m_dst = w[23:18]; m_svl = w[25:24]; m_sub = w[27:26];
      chk("R2_R3", "readback", csr_rdata, pack_state());
   endtask

   task automatic sv_set(logic [2:0] v);
      bit bad;
      bad = (v == 0 || v > 4);
      @(negedge clk); sv_we = 1; sv_len = v;
      @(negedge clk); sv_we = 0;
      if (!bad) m_svl = v - 1;
      chk("R4", "sv_illegal", sv_illegal, bad);
      chk("R4", "word after size request", csr_rdata, pack_state());
      @(negedge clk);
      chk("R4", "sv_illegal one cycle", sv_illegal, 0);
   endtask

   task automatic run_loop(logic [ML-1:0] mask, bit inv, bit zer, int ff_at, bit poke);
      int s, d, r, k;
      bit pb, ff, fin;
      logic [31:0] keep;
      pred_mask = mask; pred_inv = inv; zeroing = zer;
      s = m_sub; d = m_dst; r = m_src; k = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      forever begin
         ff = (k == ff_at);
         ffirst = ff;
         if (poke && k == 1) begin csr_we = 1; csr_wdata = 32'h0FFF_FFFF; start = 1; sv_we = 1; sv_len = 3'd1; end
         #1;
         pb = ((d < ML) ? mask[d] : 1'b0) ^ inv;
         chk("R5", "busy", busy, 1);
         chk("R5", "src_off", src_off, r);
         chk("R5", "dst_off", dst_off, d);
         chk("R5", "sub_off", sub_off, s);
         chk("R9", "live offsets in word", csr_rdata[27:12], {2'(s), 2'(m_svl), 6'(d), 6'(r)});
         chk(ff ? "R8" : "R6", "wr_en", wr_en, pb && !ff);
         chk(ff ? "R8" : "R7", "wr_zero", wr_zero, !pb && zer && !ff);
         chk("R10", "done low while busy", done, 0);
         fin = ff || (s >= m_svl && d >= m_len);
         if (s >= m_svl) begin s = 0; d++; r++; end else s++;
         k++;
         @(negedge clk);
         ffirst = 0; csr_we = 0; start = 0; sv_we = 0;
         if (fin) break;
      end
      m_src = 0; m_dst = 0; m_sub = 0;
      #1;
      chk("R10", "done pulse", done, 1);
      chk("R8", "busy low at end", busy, 0);
      chk("R9", "offsets cleared", csr_rdata, pack_state());
      @(negedge clk); #1;
      chk("R10", "done one cycle", done, 0);
      chk("R10", "no restart", busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk("R1", "reset word", csr_rdata, 0);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset done", done, 0);
      chk("R1", "reset wr", {wr_en, wr_zero, sv_illegal}, 0);

      // R11 single-element loop
      run_loop('1, 0, 0, -1, 0);

      // R2 R3 clamps and reserved bits
      do_write(32'hF000_0F3F);
      chk("R3", "maxl capped", csr_rdata[5:0], ML-1);
      chk("R3", "len capped", csr_rdata[11:6], ML-1);
      chk("R2", "reserved zero", csr_rdata[31:28], 0);
      do_write({4'hA, 2'd1, 2'd3, 6'd0, 6'd0, 6'd9, 6'd5});
      chk("R3", "len capped to maxl", csr_rdata[11:6], 5);

      // R4 group size requests
      sv_set(3'd0); sv_set(3'd5); sv_set(3'd7);
      sv_set(3'd3);
      chk("R4", "code for 3", csr_rdata[25:24], 2);
      sv_set(3'd4); sv_set(3'd1); sv_set(3'd2);

      // R5 R6 R7 R10: three elements, groups of three, inverted mask, zeroing, busy pokes
      do_write({4'h0, 2'd0, 2'd2, 6'd0, 6'd0, 6'd2, 6'd10});
      run_loop(48'b101, 1, 1, -1, 1);
      chk("R10", "writes while busy ignored", csr_rdata, pack_state());
      run_loop(48'b110, 0, 0, -1, 0);

      // R9 resume mid-loop
      do_write({4'h0, 2'd1, 2'd1, 6'd1, 6'd1, 6'd3, 6'd10});
      run_loop(48'hFF, 0, 1, -1, 0);

      // R8 abort at step 4
      do_write({4'h0, 2'd0, 2'd3, 6'd0, 6'd0, 6'd4, 6'd10});
      run_loop(48'h5, 0, 1, 4, 0);

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [5:0] mx, ln, dd;
         logic [1:0] sv, sb;
         int ffa;
         mx = 6'($urandom_range(0, 63));
         ln = 6'($urandom_range(0, 20));
         sv = 2'($urandom_range(0, 3));
         if (ln > mx) dd = 0; else dd = 6'($urandom_range(0, ln));
         sb = 2'($urandom_range(0, sv));
         do_write({4'($urandom), sb, sv, dd, dd, ln, mx});
         if ($urandom_range(0, 3) == 0) sv_set(3'($urandom_range(0, 7)));
         if (m_sub > m_svl) begin m_sub = 0; do_write(pack_state()); end
         ffa = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 30)) : -1;
         run_loop({$urandom, $urandom}, 1'($urandom), 1'($urandom), ffa, 1'($urandom));
      end
      summary();
   end
endmodule